// File: doc/BRIEF.md
# Partially protected register file

This block is a 32-entry, 32-bit register file with two combinational read ports and one write port. Error-correcting protection is given only to the K registers with the highest indices. Protection follows from the register index alone. No per-write choice is made, no table is consulted and no spare entry is allocated. A write to a protected register stores seven check bits beside the data. These form a single-error-correcting, double-error-detecting Hamming code. A read from a protected register checks the stored word, repairs any single flipped bit in the returned data and reports a double flip.

Writes and reads of unprotected registers bypass the code logic entirely. The encoder and checker inputs are held at zero for them, and three activity outputs show when each piece of code logic is in use. A fault-injection input flips one chosen stored bit of one chosen register. This lets a bench exercise correction and detection. Register 0 is hardwired to zero.

Top module: `prot_regfile`

## Requirements
- R1: A write (we high at a rising clock edge) stores wdata in register waddr. Each read port returns the addressed register combinationally. A read in a later cycle returns the written value with both error flags low.
- R2: Register 0 always reads as zero with both flags low. Writes and fault injections aimed at it have no effect.
- R3: Register i is protected exactly when i is nonzero and i >= 32-K. With the default K=7 that is registers 25 to 31.
- R4: After one stored bit of a protected register is flipped, a read returns the originally written data with the correctable flag high and the uncorrectable flag low. Stored bit numbers 0..31 are data bits d[n]. Numbers 32..38 are the seven check bits.
- R5: After two distinct stored bits of a protected register are flipped, a read raises the uncorrectable flag and leaves the correctable flag low.
- R6: A flipped data bit in an unprotected register shows up unchanged in the read data, with both flags low.
- R7: enc_busy is high only while a write targets a protected register. chk_busy_a and chk_busy_b are high only while their port addresses a protected register.
- R8: A read of a register in the same cycle as a write to it returns the old value. The new value appears after the edge.
- R9: With inj_en high at a rising edge, bit inj_bit of register inj_addr's stored word is inverted. A write to the same register in the same cycle takes precedence. Injection into check bits of an unprotected register has no effect.
- R10: Reset clears every register to zero with a consistent code, so every read after reset returns zero with both flags low.
- R11: Each read port has its own pair of flags, valid in the same cycle as its read data. An error on one port never raises the flags of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| we | input | 1 | Write enable |
| waddr | input | 5 | Write register index |
| wdata | input | 32 | Write data |
| ra_addr | input | 5 | Read port A register index |
| ra_data | output | 32 | Read port A data, corrected when protected |
| ra_corr | output | 1 | Port A single-bit error corrected |
| ra_uncorr | output | 1 | Port A double-bit error detected |
| rb_addr | input | 5 | Read port B register index |
| rb_data | output | 32 | Read port B data, corrected when protected |
| rb_corr | output | 1 | Port B single-bit error corrected |
| rb_uncorr | output | 1 | Port B double-bit error detected |
| inj_en | input | 1 | Fault-injection strobe |
| inj_addr | input | 5 | Register to corrupt |
| inj_bit | input | 6 | Stored bit to invert (0..31 data, 32..38 check) |
| enc_busy | output | 1 | Encoder in use by this cycle's write |
| chk_busy_a | output | 1 | Checker of port A in use |
| chk_busy_b | output | 1 | Checker of port B in use |

## Verification
Read data, both flag pairs and the three activity outputs are combinational. They are due in the same cycle the addresses are applied. The bench changes addresses at the falling edge and samples one nanosecond later, well before the next rising edge.

Writes and injections take effect at the first rising edge after they are driven, so their results are read only after that edge. The same-cycle old-value check is sampled before the edge, and the new value is sampled after it. The bench sweeps every stored bit of every protected register for single flips and for adjacent pairs of flips. It also flips every data bit of every unprotected register.

// File: rtl/prot_regfile.sv
module prot_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32,
  parameter int K    = 7,
  parameter int AW   = $clog2(NREG),
  parameter int HB   = $clog2(W + $clog2(W) + 1),
  parameter int CB   = HB + 1,
  parameter int IW   = $clog2(W + CB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra_addr,
  output logic [W-1:0]  ra_data,
  output logic          ra_corr,
  output logic          ra_uncorr,
  input  logic [AW-1:0] rb_addr,
  output logic [W-1:0]  rb_data,
  output logic          rb_corr,
  output logic          rb_uncorr,
  input  logic          inj_en,
  input  logic [AW-1:0] inj_addr,
  input  logic [IW-1:0] inj_bit,
  output logic          enc_busy,
  output logic          chk_busy_a,
  output logic          chk_busy_b
);
  localparam int FIRST = NREG - K;
  localparam int PMAX  = 4 * W + 16;

  function automatic int dpos(input int j);
    int n;
    dpos = 0;
    n = -1;
    for (int p = 3; p < PMAX; p++) begin
      if ((p & (p - 1)) != 0) begin
        n++;
        if (n == j) dpos = p;
      end
    end
  endfunction

  function automatic logic [HB-1:0] syn(input logic [W-1:0] d);
    syn = '0;
    for (int j = 0; j < W; j++)
      for (int i = 0; i < HB; i++)
        if (((dpos(j) >> i) & 1) == 1) syn[i] = syn[i] ^ d[j];
  endfunction

  function automatic logic [W+1:0] fix(input logic [W-1:0] d, input logic [CB-1:0] k);
    logic [HB-1:0] s;
    logic          ov;
    logic [W-1:0]  o;
    s  = k[HB-1:0] ^ syn(d);
    ov = (^d) ^ (^k);
    o  = d;
    if (ov)
      for (int j = 0; j < W; j++)
        if (s == HB'(dpos(j))) o[j] = ~d[j];
    fix = {ov, !ov && (s != '0), o};
  endfunction

  function automatic logic prot(input logic [AW-1:0] a);
    return (a != '0) && (int'(a) >= FIRST);
  endfunction

  logic [W-1:0]  dq [NREG];
  logic [CB-1:0] cq [NREG];
  logic [W-1:0]  enc_in;
  logic [HB-1:0] enc_s;
  logic [CB-1:0] enc_chk;
  logic          inj_data, inj_code;

  assign enc_busy = we & prot(waddr);
  assign enc_in   = enc_busy ? wdata : '0;
  assign enc_s    = syn(enc_in);
  assign enc_chk  = {(^enc_in) ^ (^enc_s), enc_s};
  assign inj_data = inj_en && (inj_bit < IW'(W));
  assign inj_code = inj_en && (inj_bit >= IW'(W)) && (inj_bit < IW'(W + CB));

  assign dq[0] = '0;
  assign cq[0] = '0;

  for (genvar i = 1; i < NREG; i++) begin : g_reg
    logic [W-1:0] d_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    d_q <= '0;
      else if (we && waddr == AW'(i))                d_q <= wdata;
      else if (inj_data && inj_addr == AW'(i))       d_q <= d_q ^ (W'(1) << inj_bit);
    end
    assign dq[i] = d_q;
    if (i >= FIRST) begin : g_code
      logic [CB-1:0] c_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  c_q <= '0;
        else if (we && waddr == AW'(i))              c_q <= enc_chk;
        else if (inj_code && inj_addr == AW'(i))     c_q <= c_q ^ (CB'(1) << (inj_bit - IW'(W)));
      end
      assign cq[i] = c_q;
    end else begin : g_plain
      assign cq[i] = '0;
    end
  end

  logic [W+1:0] fa, fb;

  assign chk_busy_a = prot(ra_addr);
  assign fa         = fix(chk_busy_a ? dq[ra_addr] : '0, chk_busy_a ? cq[ra_addr] : '0);
  assign ra_data    = chk_busy_a ? fa[W-1:0] : dq[ra_addr];
  assign ra_corr    = chk_busy_a & fa[W+1];
  assign ra_uncorr  = chk_busy_a & fa[W];

  assign chk_busy_b = prot(rb_addr);
  assign fb         = fix(chk_busy_b ? dq[rb_addr] : '0, chk_busy_b ? cq[rb_addr] : '0);
  assign rb_data    = chk_busy_b ? fb[W-1:0] : dq[rb_addr];
  assign rb_corr    = chk_busy_b & fb[W+1];
  assign rb_uncorr  = chk_busy_b & fb[W];

  p_wr_rd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr != '0 && !inj_en) |=>
      (ra_addr != $past(waddr)) || (ra_data == $past(wdata) && !ra_corr && !ra_uncorr));

  p_r0_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_addr == '0) |-> (rb_data == '0 && !rb_corr && !rb_uncorr));

  p_enc_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!we || int'(waddr) < FIRST) |-> !enc_busy);

  p_flag_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ra_corr && ra_uncorr) && !(rb_corr && rb_uncorr));

  p_reset_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!ra_corr && !ra_uncorr && !rb_corr && !rb_uncorr));
endmodule

// File: tb/prot_regfile_bench.sv
module prot_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  waddr = '0;
  logic [31:0] wdata = '0;
  logic [4:0]  ra_addr = '0, rb_addr = '0, inj_addr = '0;
  logic [5:0]  inj_bit = '0;
  logic        inj_en = 1'b0;
  logic [31:0] ra_data, rb_data;
  logic        ra_corr, ra_uncorr, rb_corr, rb_uncorr;
  logic        enc_busy, chk_busy_a, chk_busy_b;

  int nchk = 0, nerr = 0;
  bit done = 0;
  logic [31:0] mdl [32];

  always #4 clk = ~clk;

  prot_regfile u_prot_regfile (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
    .ra_addr(ra_addr), .ra_data(ra_data), .ra_corr(ra_corr), .ra_uncorr(ra_uncorr),
    .rb_addr(rb_addr), .rb_data(rb_data), .rb_corr(rb_corr), .rb_uncorr(rb_uncorr),
    .inj_en(inj_en), .inj_addr(inj_addr), .inj_bit(inj_bit),
    .enc_busy(enc_busy), .chk_busy_a(chk_busy_a), .chk_busy_b(chk_busy_b));

  function automatic bit is_prot(input int r);
    return r != 0 && r >= 25;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input int a, input int b);
    ra_addr = 5'(a);
    rb_addr = 5'(b);
    #1;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; waddr = 5'(a); wdata = d;
    #1;
    chk("R7 enc_busy on write", 32'(enc_busy), 32'(is_prot(a)));
    @(negedge clk);
    we = 1'b0;
    if (a != 0) mdl[a] = d;
  endtask

  task automatic inj(input int a, input int b);
    @(negedge clk);
    inj_en = 1'b1; inj_addr = 5'(a); inj_bit = 6'(b);
    @(negedge clk);
    inj_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: all clean zeros after reset; R3/R7 checker activity by index
    for (int i = 0; i < 32; i++) begin
      rd(i, 31 - i);
      chk("R10 reset data a", ra_data, 32'h0);
      chk("R10 reset data b", rb_data, 32'h0);
      chk("R10 reset flags", {28'h0, ra_corr, ra_uncorr, rb_corr, rb_uncorr}, 32'h0);
      chk("R3 chk_busy_a", 32'(chk_busy_a), 32'(is_prot(i)));
      chk("R7 chk_busy_b", 32'(chk_busy_b), 32'(is_prot(31 - i)));
    end
    // R1/R2: fill all registers
    for (int i = 0; i < 32; i++) wr(i, (32'h9E3779B9 * 32'(i + 1)) ^ (32'(i) << 24));
    for (int i = 0; i < 32; i++) begin
      rd(i, (i + 7) % 32);
      chk("R1 read a", ra_data, mdl[i]);
      chk("R1 read b", rb_data, mdl[(i + 7) % 32]);
      chk("R1 flags", {30'h0, ra_corr, ra_uncorr}, 32'h0);
    end
    rd(0, 0);
    chk("R2 r0 reads zero", ra_data, 32'h0);
    // R8: same-cycle write/read returns old value
    for (int r = 24; r < 27; r++) begin
      @(negedge clk);
      we = 1'b1; waddr = 5'(r); wdata = ~mdl[r];
      rd(r, r);
      chk("R8 old value", ra_data, mdl[r]);
      @(negedge clk);
      we = 1'b0;
      mdl[r] = ~mdl[r];
      rd(r, 0);
      chk("R8 new value", ra_data, mdl[r]);
      chk("R8 flags", {30'h0, ra_corr, ra_uncorr}, 32'h0);
    end
    // R4/R11: every single stored-bit flip in every protected register
    for (int r = 25; r < 32; r++)
      for (int b = 0; b < 39; b++) begin
        inj(r, b);
        rd(r, 1);
        chk("R4 corrected data", ra_data, mdl[r]);
        chk("R4 flags corr/uncorr", {30'h0, ra_corr, ra_uncorr}, 32'h2);
        chk("R11 other port flags", {30'h0, rb_corr, rb_uncorr}, 32'h0);
        inj(r, b);
        rd(r, r);
        chk("R4 restored flags", {28'h0, ra_corr, ra_uncorr, rb_corr, rb_uncorr}, 32'h0);
      end
    // R5/R11: adjacent pairs of flips
    for (int r = 25; r < 32; r++)
      for (int b = 0; b < 39; b++) begin
        inj(r, b);
        inj(r, (b + 1) % 39);
        rd((r == 25) ? 26 : 25, r);
        chk("R5 flags corr/uncorr", {30'h0, rb_corr, rb_uncorr}, 32'h1);
        chk("R11 other port clean", {30'h0, ra_corr, ra_uncorr}, 32'h0);
        inj(r, b);
        inj(r, (b + 1) % 39);
      end
    // R6: unprotected flips pass through unflagged
    for (int r = 1; r < 25; r++)
      for (int b = 0; b < 32; b++) begin
        inj(r, b);
        rd(r, r);
        chk("R6 raw flipped data", ra_data, mdl[r] ^ (32'h1 << b));
        chk("R6 flags", {28'h0, ra_corr, ra_uncorr, rb_corr, rb_uncorr}, 32'h0);
        inj(r, b);
      end
    // R9: check-bit injection into unprotected register is ignored
    inj(3, 35);
    rd(3, 0);
    chk("R9 unprotected check-bit inject", ra_data, mdl[3]);
    // R2: injection into register 0 has no effect
    inj(0, 3);
    rd(0, 0);
    chk("R2 r0 after inject", ra_data, 32'h0);
    // R9: write wins over same-cycle injection
    @(negedge clk);
    we = 1'b1; waddr = 5'd28; wdata = 32'hCAFE_0123;
    inj_en = 1'b1; inj_addr = 5'd28; inj_bit = 6'd4;
    @(negedge clk);
    we = 1'b0; inj_en = 1'b0;
    mdl[28] = 32'hCAFE_0123;
    rd(28, 0);
    chk("R9 write wins data", ra_data, mdl[28]);
    chk("R9 write wins flags", {30'h0, ra_corr, ra_uncorr}, 32'h0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule